// File: doc/BRIEF.md
# Hybrid Coherence Directory Controller

This block holds the sharer record for every line of an inclusive, write-through memory cache. Each line is in one of two modes. In list mode the line keeps the exact set of L1 caches that hold a copy. The set lives as a chain of entries in a copy table that all lines share. In count mode the line keeps only the number of copies.

Read registrations add sharers and cleanups remove them. When a write arrives, the block emits coherence commands on a valid/ready stream. A list-mode line gets one update per listed sharer, leaving out the writer. A count-mode line gets one broadcast invalidate. A line moves to count mode when its set would grow past a threshold, or when the copy table has no free entry left.

Requests are taken one at a time. The request port stays closed until the current request has been fully processed and its last command has been accepted. Free copy-table entries form a linked stack, so one entry is taken or given back per cycle.

Top module: `hcdir_ctrl`

## Requirements
- R1: After reset every line is in list mode with no sharers, `req_ready` is high and `cmd_valid` is low.
- R2: A read registration (op 0) on a list-mode line adds the requester to the chain. A write (op 1) on a list-mode line emits one command of kind 0 (update) per listed sharer whose id differs from the writer. The commands come newest registration first, each carrying the line index and the sharer id.
- R3: A read registration from an id already listed on the line leaves the chain unchanged and takes no copy-table entry.
- R4: A cleanup (op 2) on a list-mode line removes that id from the chain and returns its entry to the free stack. A cleanup naming an id that is not listed has no effect.
- R5: A read that would make a list-mode line exceed THRESH sharers moves the line to count mode, with the count set to the old list length plus one. All of that line's chain entries are returned to the free stack.
- R6: A read on a list-mode line that needs an entry while the free stack is empty moves the line to count mode with the count set to the list length plus one. No sharer is dropped silently.
- R7: A write on a count-mode line emits exactly one command of kind 1 (broadcast invalidate), carrying the line index and the writer id. The line is then in list mode with no sharers.
- R8: In count mode a read adds one to the count, saturating at its maximum, and a cleanup subtracts one. When the count reaches zero, the line returns to list mode with no sharers.
- R9: Commands leave at most one per cycle. A command is held unchanged while `cmd_valid` is high and `cmd_ready` is low. `req_ready` stays low from the accepting edge until the last command of the request has been taken and processing has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting a request |
| req_op | input | 2 | 0 read registration, 1 write, 2 cleanup, 3 no operation |
| req_line | input | LINE_W | Cache line index |
| req_id | input | ID_W | Requesting L1 identifier |
| cmd_valid | output | 1 | Coherence command present |
| cmd_ready | input | 1 | Command sink accepts |
| cmd_kind | output | 1 | 0 update to one sharer, 1 broadcast invalidate |
| cmd_line | output | LINE_W | Line the command refers to |
| cmd_id | output | ID_W | Target sharer (update) or writer (broadcast) |

## Verification
A request is taken at the edge where `req_valid` and `req_ready` are both high. The following cycle reads the line state, and the chain is then walked one entry per cycle. The earliest command is therefore visible two cycles after acceptance, and `req_ready` returns only after the final walk step or the final accepted command. The bench drives and samples on the falling edge and counts a command only when it sees valid and ready together at that point. It also waits for `req_ready` to return before issuing the next request. Read and cleanup have no direct output, so their effect, including mode changes, copy-table exhaustion and entry recycling, is checked through the command sequence of the next write, compared against a per-line reference sharer set.

// File: rtl/hcdir_pkg.sv
package hcdir_pkg;

  typedef enum logic [1:0] {
    OP_READ    = 2'd0,
    OP_WRITE   = 2'd1,
    OP_CLEANUP = 2'd2,
    OP_NONE    = 2'd3
  } req_op_e;

  typedef enum logic {
    KIND_UPDATE    = 1'b0,
    KIND_BCAST_INV = 1'b1
  } cmd_kind_e;

  typedef enum logic {
    MODE_LIST  = 1'b0,
    MODE_COUNT = 1'b1
  } line_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_RD_WALK,
    ST_SPILL,
    ST_CL_WALK,
    ST_WR_WALK,
    ST_WR_BCAST
  } fsm_e;

endpackage

// File: rtl/hcdir_copy_table.sv
module hcdir_copy_table
  import hcdir_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int ID_W  = 13,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  // combinational read port
  input  logic [PTR_W-1:0] rd_ptr,
  output logic [ID_W-1:0]  rd_id,
  output logic [PTR_W-1:0] rd_next,
  output logic             rd_last,
  // free stack head
  output logic [PTR_W-1:0] free_head,
  output logic             free_empty,
  // pop the free head and fill it
  input  logic             alloc_en,
  input  logic [ID_W-1:0]  alloc_id,
  input  logic [PTR_W-1:0] alloc_next,
  input  logic             alloc_last,
  // push one entry back on the free stack
  input  logic             rel_en,
  input  logic [PTR_W-1:0] rel_ptr,
  // relink one entry
  input  logic             lnk_en,
  input  logic [PTR_W-1:0] lnk_ptr,
  input  logic [PTR_W-1:0] lnk_next,
  input  logic             lnk_last
);

  logic [ID_W-1:0]  ent_id   [DEPTH];
  logic [PTR_W-1:0] ent_next [DEPTH];
  logic             ent_last [DEPTH];

  logic [PTR_W-1:0] fhead_q, fhead_nx;
  logic             fempty_q, fempty_nx;

  assign rd_id      = ent_id[rd_ptr];
  assign rd_next    = ent_next[rd_ptr];
  assign rd_last    = ent_last[rd_ptr];
  assign free_head  = fhead_q;
  assign free_empty = fempty_q;

  always_comb begin
    fhead_nx  = fhead_q;
    fempty_nx = fempty_q;
    if (alloc_en) begin
      fhead_nx  = ent_next[fhead_q];
      fempty_nx = ent_last[fhead_q];
    end else if (rel_en) begin
      fhead_nx  = rel_ptr;
      fempty_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fhead_q  <= '0;
      fempty_q <= 1'b0;
    end else if (alloc_en || rel_en) begin
      fhead_q  <= fhead_nx;
      fempty_q <= fempty_nx;
    end
  end

  // entry storage; reset threads every entry onto the free stack
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        ent_id[i]   <= '0;
        ent_next[i] <= (i == DEPTH - 1) ? '0 : PTR_W'(i + 1);
        ent_last[i] <= (i == DEPTH - 1);
      end
    end else begin
      if (alloc_en) begin
        ent_id[fhead_q]   <= alloc_id;
        ent_next[fhead_q] <= alloc_next;
        ent_last[fhead_q] <= alloc_last;
      end
      if (rel_en) begin
        ent_next[rel_ptr] <= fhead_q;
        ent_last[rel_ptr] <= fempty_q;
      end
      if (lnk_en) begin
        ent_next[lnk_ptr] <= lnk_next;
        ent_last[lnk_ptr] <= lnk_last;
      end
    end
  end

  p_alloc_needs_free_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !fempty_q);

  p_no_double_release_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    rel_en |-> (fempty_q || rel_ptr != fhead_q));

  p_single_stack_op_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    !(alloc_en && rel_en));

endmodule

// File: rtl/hcdir_line_state.sv
module hcdir_line_state
  import hcdir_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 14,
  parameter int THRESH = 4,
  localparam int LINE_W = $clog2(LINES),
  localparam int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] rd_line,
  output line_mode_e        rd_mode,
  output logic [PTR_W-1:0]  rd_head,
  output logic [CNT_W-1:0]  rd_cnt,
  input  logic              wr_en,
  input  logic [LINE_W-1:0] wr_line,
  input  line_mode_e        wr_mode,
  input  logic [PTR_W-1:0]  wr_head,
  input  logic [CNT_W-1:0]  wr_cnt
);

  logic [LINES-1:0]            mode_all;
  logic [LINES-1:0][PTR_W-1:0] head_all;
  logic [LINES-1:0][CNT_W-1:0] cnt_all;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    line_mode_e       mode_q;
    logic [PTR_W-1:0] head_q;
    logic [CNT_W-1:0] cnt_q;
    logic             line_we;

    assign line_we = wr_en && (wr_line == LINE_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode_q <= MODE_LIST;
        head_q <= '0;
        cnt_q  <= '0;
      end else if (line_we) begin
        mode_q <= wr_mode;
        head_q <= wr_head;
        cnt_q  <= wr_cnt;
      end
    end

    assign mode_all[g] = mode_q;
    assign head_all[g] = head_q;
    assign cnt_all[g]  = cnt_q;
  end

  assign rd_mode = line_mode_e'(mode_all[rd_line]);
  assign rd_head = head_all[rd_line];
  assign rd_cnt  = cnt_all[rd_line];

  p_list_bound_r5 : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_mode == MODE_LIST) |-> (int'(wr_cnt) <= THRESH));

  p_count_nonzero_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_mode == MODE_COUNT) |-> (wr_cnt != '0));

endmodule

// File: rtl/hcdir_ctrl.sv
module hcdir_ctrl
  import hcdir_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int DEPTH  = 16,
  parameter int ID_W   = 13,
  parameter int CNT_W  = 14,
  parameter int THRESH = 4,
  localparam int LINE_W = $clog2(LINES),
  localparam int PTR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [LINE_W-1:0] req_line,
  input  logic [ID_W-1:0]   req_id,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_kind,
  output logic [LINE_W-1:0] cmd_line,
  output logic [ID_W-1:0]   cmd_id
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_THR = CNT_W'(THRESH);

  fsm_e              st_q, st_nx;
  req_op_e           op_q, op_nx;
  logic [LINE_W-1:0] line_q, line_nx;
  logic [ID_W-1:0]   id_q, id_nx;
  logic [PTR_W-1:0]  cur_q, cur_nx;
  logic [PTR_W-1:0]  prev_q, prev_nx;
  logic              prev_vld_q, prev_vld_nx;

  // line state
  line_mode_e        d_mode;
  logic [PTR_W-1:0]  d_head;
  logic [CNT_W-1:0]  d_cnt;
  logic              dw_en;
  line_mode_e        dw_mode;
  logic [PTR_W-1:0]  dw_head;
  logic [CNT_W-1:0]  dw_cnt;

  // copy table
  logic [ID_W-1:0]   ct_id;
  logic [PTR_W-1:0]  ct_next;
  logic              ct_last;
  logic [PTR_W-1:0]  free_head;
  logic              free_empty;
  logic              alloc_en, alloc_last;
  logic [PTR_W-1:0]  alloc_next;
  logic              rel_en;
  logic [PTR_W-1:0]  rel_ptr;
  logic              lnk_en, lnk_last;
  logic [PTR_W-1:0]  lnk_ptr, lnk_next;

  logic              hit;
  logic              list_full;

  hcdir_line_state #(
    .LINES (LINES),
    .DEPTH (DEPTH),
    .CNT_W (CNT_W),
    .THRESH(THRESH)
  ) i_lines (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_line(line_q),
    .rd_mode(d_mode),
    .rd_head(d_head),
    .rd_cnt (d_cnt),
    .wr_en  (dw_en),
    .wr_line(line_q),
    .wr_mode(dw_mode),
    .wr_head(dw_head),
    .wr_cnt (dw_cnt)
  );

  hcdir_copy_table #(
    .DEPTH(DEPTH),
    .ID_W (ID_W)
  ) i_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_ptr    (cur_q),
    .rd_id     (ct_id),
    .rd_next   (ct_next),
    .rd_last   (ct_last),
    .free_head (free_head),
    .free_empty(free_empty),
    .alloc_en  (alloc_en),
    .alloc_id  (id_q),
    .alloc_next(alloc_next),
    .alloc_last(alloc_last),
    .rel_en    (rel_en),
    .rel_ptr   (rel_ptr),
    .lnk_en    (lnk_en),
    .lnk_ptr   (lnk_ptr),
    .lnk_next  (lnk_next),
    .lnk_last  (lnk_last)
  );

  assign hit       = (ct_id == id_q);
  assign list_full = (d_cnt >= CNT_THR) || free_empty;

  assign req_ready = (st_q == ST_IDLE);
  assign cmd_valid = ((st_q == ST_WR_WALK) && !hit) || (st_q == ST_WR_BCAST);
  assign cmd_kind  = (st_q == ST_WR_BCAST) ? KIND_BCAST_INV : KIND_UPDATE;
  assign cmd_line  = line_q;
  assign cmd_id    = (st_q == ST_WR_BCAST) ? id_q : ct_id;

  always_comb begin
    st_nx       = st_q;
    op_nx       = op_q;
    line_nx     = line_q;
    id_nx       = id_q;
    cur_nx      = cur_q;
    prev_nx     = prev_q;
    prev_vld_nx = prev_vld_q;
    dw_en       = 1'b0;
    dw_mode     = d_mode;
    dw_head     = d_head;
    dw_cnt      = d_cnt;
    alloc_en    = 1'b0;
    alloc_next  = d_head;
    alloc_last  = 1'b0;
    rel_en      = 1'b0;
    rel_ptr     = cur_q;
    lnk_en      = 1'b0;
    lnk_ptr     = prev_q;
    lnk_next    = ct_next;
    lnk_last    = ct_last;

    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          op_nx   = req_op_e'(req_op);
          line_nx = req_line;
          id_nx   = req_id;
          st_nx   = ST_LOOKUP;
        end
      end

      ST_LOOKUP: begin
        cur_nx      = d_head;
        prev_vld_nx = 1'b0;
        st_nx       = ST_IDLE;
        unique case (op_q)
          OP_READ: begin
            if (d_mode == MODE_COUNT) begin
              dw_en  = 1'b1;
              dw_cnt = (d_cnt == CNT_MAX) ? d_cnt : d_cnt + CNT_ONE;
            end else if (d_cnt == '0) begin
              dw_en  = 1'b1;
              dw_cnt = CNT_ONE;
              if (free_empty) begin
                dw_mode = MODE_COUNT;
              end else begin
                alloc_en   = 1'b1;
                alloc_last = 1'b1;
                dw_head    = free_head;
              end
            end else begin
              st_nx = ST_RD_WALK;
            end
          end
          OP_CLEANUP: begin
            if (d_mode == MODE_COUNT) begin
              dw_en  = 1'b1;
              dw_cnt = d_cnt - CNT_ONE;
              if (d_cnt == CNT_ONE) dw_mode = MODE_LIST;
            end else if (d_cnt != '0) begin
              st_nx = ST_CL_WALK;
            end
          end
          OP_WRITE: begin
            if (d_mode == MODE_COUNT) st_nx = ST_WR_BCAST;
            else if (d_cnt != '0)     st_nx = ST_WR_WALK;
          end
          default: st_nx = ST_IDLE;
        endcase
      end

      // duplicate search, then append or spill into count mode
      ST_RD_WALK: begin
        if (hit) begin
          st_nx = ST_IDLE;
        end else if (!ct_last) begin
          cur_nx = ct_next;
        end else begin
          dw_en  = 1'b1;
          dw_cnt = d_cnt + CNT_ONE;
          if (list_full) begin
            dw_mode = MODE_COUNT;
            cur_nx  = d_head;
            st_nx   = ST_SPILL;
          end else begin
            alloc_en   = 1'b1;
            alloc_next = d_head;
            alloc_last = 1'b0;
            dw_head    = free_head;
            st_nx      = ST_IDLE;
          end
        end
      end

      // hand the abandoned chain back, one entry per cycle
      ST_SPILL: begin
        rel_en = 1'b1;
        if (ct_last) st_nx = ST_IDLE;
        else         cur_nx = ct_next;
      end

      ST_CL_WALK: begin
        if (hit) begin
          rel_en = 1'b1;
          dw_en  = 1'b1;
          dw_cnt = d_cnt - CNT_ONE;
          if (prev_vld_q) lnk_en  = 1'b1;
          else            dw_head = ct_next;
          st_nx = ST_IDLE;
        end else if (ct_last) begin
          st_nx = ST_IDLE;
        end else begin
          prev_nx     = cur_q;
          prev_vld_nx = 1'b1;
          cur_nx      = ct_next;
        end
      end

      ST_WR_WALK: begin
        if (hit || cmd_ready) begin
          if (ct_last) st_nx = ST_IDLE;
          else         cur_nx = ct_next;
        end
      end

      ST_WR_BCAST: begin
        if (cmd_ready) begin
          dw_en   = 1'b1;
          dw_mode = MODE_LIST;
          dw_cnt  = '0;
          st_nx   = ST_IDLE;
        end
      end

      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      op_q       <= OP_NONE;
      line_q     <= '0;
      id_q       <= '0;
      cur_q      <= '0;
      prev_q     <= '0;
      prev_vld_q <= 1'b0;
    end else begin
      st_q       <= st_nx;
      op_q       <= op_nx;
      line_q     <= line_nx;
      id_q       <= id_nx;
      cur_q      <= cur_nx;
      prev_q     <= prev_nx;
      prev_vld_q <= prev_vld_nx;
    end
  end

  p_cmd_hold_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=>
      (cmd_valid && $stable(cmd_id) && $stable(cmd_kind) && $stable(cmd_line)));

  p_bcast_ends_r7 : assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_kind == KIND_BCAST_INV) |=> req_ready);

endmodule

// File: tb/test_hcdir_ctrl.sv
`timescale 1ns/100ps
module test_hcdir_ctrl;

  localparam int LINES  = 4;
  localparam int DEPTH  = 4;
  localparam int ID_W   = 4;
  localparam int CNT_W  = 5;
  localparam int THRESH = 3;
  localparam int LW     = 2;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [1:0]    req_op;
  logic [LW-1:0] req_line;
  logic [ID_W-1:0] req_id;
  logic          cmd_valid;
  logic          cmd_ready;
  logic          cmd_kind;
  logic [LW-1:0] cmd_line;
  logic [ID_W-1:0] cmd_id;

  always #2.5 clk = ~clk;

  hcdir_ctrl #(
    .LINES(LINES), .DEPTH(DEPTH), .ID_W(ID_W), .CNT_W(CNT_W), .THRESH(THRESH)
  ) i_hcdir_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_line(req_line), .req_id(req_id),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_line(cmd_line), .cmd_id(cmd_id)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference model
  int m_ids [LINES][THRESH];
  int m_n   [LINES];
  bit m_ctr [LINES];
  int m_cnt [LINES];
  int m_free;
  int exp_kind [THRESH + 1];
  int exp_id   [THRESH + 1];
  int exp_n;
  bit stall;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_update(input int op, input int l, input int id);
    if (op == 0) begin
      if (m_ctr[l]) begin
        if (m_cnt[l] < CMAX) m_cnt[l]++;
      end else begin
        bit dup = 0;
        for (int k = 0; k < m_n[l]; k++) if (m_ids[l][k] == id) dup = 1;
        if (!dup) begin
          if (m_n[l] + 1 > THRESH || m_free == 0) begin
            m_ctr[l] = 1; m_cnt[l] = m_n[l] + 1; m_free += m_n[l]; m_n[l] = 0;
          end else begin
            m_ids[l][m_n[l]] = id; m_n[l]++; m_free--;
          end
        end
      end
    end else if (op == 2) begin
      if (m_ctr[l]) begin
        m_cnt[l]--;
        if (m_cnt[l] == 0) begin m_ctr[l] = 0; m_n[l] = 0; end
      end else begin
        int pos = -1;
        for (int k = 0; k < m_n[l]; k++) if (m_ids[l][k] == id) pos = k;
        if (pos >= 0) begin
          for (int k = pos; k < m_n[l] - 1; k++) m_ids[l][k] = m_ids[l][k + 1];
          m_n[l]--; m_free++;
        end
      end
    end else if (op == 1) begin
      if (m_ctr[l]) begin m_ctr[l] = 0; m_n[l] = 0; end
    end
  endtask

  task automatic run(input int op, input int l, input int id, input string tag);
    int got = 0;
    bit ph = 0;
    bit busy_ok = 1;
    exp_n = 0;
    if (op == 1) begin
      if (m_ctr[l]) begin
        exp_kind[0] = 1; exp_id[0] = id; exp_n = 1;
      end else begin
        for (int k = m_n[l] - 1; k >= 0; k--)
          if (m_ids[l][k] != id) begin
            exp_kind[exp_n] = 0; exp_id[exp_n] = m_ids[l][k]; exp_n++;
          end
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_line = LW'(l); req_id = ID_W'(id);
    @(negedge clk);
    req_valid = 1'b0;
    forever begin
      cmd_ready = stall ? ph : 1'b1;
      ph = ~ph;
      #0;
      if (cmd_valid && req_ready) busy_ok = 0;
      if (cmd_valid && cmd_ready) begin
        if (got < exp_n) begin
          check(cmd_kind == exp_kind[got][0], tag, "cmd kind", cmd_kind, exp_kind[got]);
          check(int'(cmd_id) == exp_id[got], tag, "cmd id", cmd_id, exp_id[got]);
          check(int'(cmd_line) == l, tag, "cmd line", cmd_line, l);
        end else begin
          check(1'b0, tag, "extra command id", cmd_id, -1);
        end
        got++;
      end
      if (req_ready && !cmd_valid) break;
      @(negedge clk);
    end
    cmd_ready = 1'b0;
    if (op == 1) check(got == exp_n, tag, "command count", got, exp_n);
    check(busy_ok, "R9", "ready while command pending", !busy_ok, 0);
    model_update(op, l, id);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    for (int l = 0; l < LINES; l++) begin m_n[l] = 0; m_ctr[l] = 0; m_cnt[l] = 0; end
    m_free = DEPTH;
    stall = 0;
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_line = '0; req_id = '0;
    cmd_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    check(cmd_valid == 1'b0, "R1", "cmd_valid after reset", cmd_valid, 0);
    run(1, 0, 5, "R1 empty line write");

    // R2: list build and multicast update
    run(0, 0, 1, "R2"); run(0, 0, 2, "R2"); run(0, 0, 3, "R2");
    run(1, 0, 2, "R2 write by sharer");
    // R3: duplicate registration
    run(0, 0, 2, "R3"); run(1, 0, 9, "R3 write after duplicate");
    // R4: cleanup absent then present, middle and head
    run(2, 0, 7, "R4"); run(1, 0, 9, "R4 absent cleanup ignored");
    run(2, 0, 2, "R4"); run(1, 0, 9, "R4 middle removed");
    run(2, 0, 3, "R4"); run(1, 0, 9, "R4 head removed");
    run(0, 0, 2, "R4"); run(0, 0, 3, "R4"); run(1, 0, 9, "R4 entries reused");
    // R6: table exhausted
    run(0, 1, 5, "R6"); run(0, 1, 6, "R6");
    run(1, 1, 4, "R6 exhausted line broadcasts");
    run(1, 1, 4, "R7 line empty after broadcast");
    // R5: threshold spill and entry recycling
    run(2, 0, 1, "R4"); run(2, 0, 2, "R4"); run(2, 0, 3, "R4");
    for (int i = 1; i <= 4; i++) run(0, 2, i, "R5");
    for (int i = 10; i <= 12; i++) run(0, 3, i, "R5");
    run(1, 3, 0, "R5 freed entries allocate");
    // R8: count mode arithmetic
    run(2, 2, 0, "R8"); run(2, 2, 0, "R8"); run(2, 2, 0, "R8");
    run(1, 2, 7, "R7 count one broadcasts");
    for (int i = 1; i <= 4; i++) run(0, 2, i, "R8");
    for (int i = 0; i < 4; i++) run(2, 2, 0, "R8");
    run(1, 2, 7, "R8 count zero back to list");
    run(0, 2, 6, "R8"); run(1, 2, 7, "R8 list after return");

    // near-exhaustive pseudo-random sweep, backpressure in second half
    for (int k = 0; k < 800; k++) begin
      int op, l, id;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      op = (lfsr[1:0] == 2'd3) ? 0 : int'(lfsr[1:0]);
      l  = int'(lfsr[5:4]);
      id = int'(lfsr[10:8]) % 6;
      stall = (k >= 400);
      run(op, l, id, op == 1 ? "R2 R7 sweep write" : "R9 sweep");
    end
    summary();
  end

endmodule